// File: doc/BRIEF.md
# Cartridge ROM Word Transfer Controller

This block runs read transactions on an 8-bit parallel cartridge ROM bus. Software writes a 32-bit control word that picks the bus speed and the transfer length and sets the start bit. The block then drives an 8-byte command onto the bus one byte per byte period, most significant byte first. After that it collects 32-bit words from the incoming bus bytes, least significant byte first, and places each one in a single data register.

The reader sets the pace. When a word is ready, a ready flag in the control word goes high and a one-cycle DMA request pulse goes out. Reading the data register clears the flag. Only after that read does the block fetch the next word. When the last word has been read, or when a zero-length command has finished, the busy bit drops. An interrupt pulse goes out at that point if the port's interrupt enable is set. The bus byte period is 5 system cycles, or 8 cycles when the slow-speed bit is set. Every phase latency is a whole number of byte periods.

Top module: `cart_rom_xfer`

## Requirements
- R1: After reset the control word reads 0, the data register reads 0, and `irqPulse` and `dmaReq` are low.
- R2: When not busy, a control write stores all written bits except bit 23 (ready) and bit 15, which always read 0. Bit 31 (busy) is set only when a transfer starts. Bit 27 selects the slow speed and bits 26:24 hold the size code.
- R3: A write with bit 31 set starts a transfer only when `portEnable` is high. Otherwise busy stays 0 and no byte strobe or ready flag ever appears.
- R4: The byte period P is 8 cycles when bit 27 is 1 and 5 cycles when it is 0. With a nonzero length, the ready flag is 0 through cycle 12P-1 after the start write edge and 1 at cycle 12P. `dmaReq` pulses for exactly that one cycle.
- R5: Size code 0 gives a transfer with no data words. Busy clears exactly 8P cycles after the start edge, and no ready flag is ever raised.
- R6: A data read while ready is 1 clears ready at that edge. If words remain, ready returns exactly 4P cycles later, together with a one-cycle `dmaReq`.
- R7: A data read while ready is 0 leaves the data register unchanged and does not change when the next word becomes ready.
- R8: The number of words is 0 for code 0, 1 for code 7, and 64<<code for codes 1 to 6 (which is 0x100<<code bytes). Busy stays 1 until that many words have been read.
- R9: Reading the last ready word clears busy at that edge. `irqPulse` is then high for one cycle if `portIrqEn` is 1, and stays low if it is 0. The same rule applies at the end of a zero-length transfer.
- R10: A control write while busy is ignored completely.
- R11: During the command phase, `busCmdOut` shows byte floor(k/P) of `cmdIn`, most significant byte first, k cycles after the start edge. The data word w is built from bus bytes 8+4w to 8+4w+3, counted by `busStrobe` pulses since the start, with the first byte in bits 7:0. Each byte is sampled at the edge where its `busStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word write value |
| ctrlRdData | output | 32 | Current control word (busy, ready, speed, size, stored bits) |
| dataRdEn | input | 1 | Data register read strobe from host or DMA |
| dataRdData | output | 32 | Last completed data word |
| portEnable | input | 1 | Port enable; a start is accepted only while it is high |
| portIrqEn | input | 1 | End-of-transfer interrupt enable |
| cmdIn | input | 64 | 8-byte command to send |
| busCmdOut | output | 8 | Command byte driven on the bus |
| busByteIn | input | 8 | Byte returned by the ROM bus |
| busStrobe | output | 1 | High in the last cycle of each byte period |
| dmaReq | output | 1 | One-cycle pulse when a word becomes ready |
| irqPulse | output | 1 | One-cycle end-of-transfer interrupt |

## Verification
The bench sweeps size codes 0, 1, 2, 3 and 7 at both speeds and checks ready exactly one cycle before and at each boundary of 12P and 4P. A design that counted one byte period too many or too few, or that fetched ahead without waiting for the read, fails these checks. Each transfer includes a read while not ready during a fetch, which catches a design that advances or restarts the fetch on any read. The sweep also covers a control write in the middle of a transfer, which catches a design that lets it change speed, size or busy. It also covers zero-length and single-word transfers, where ending too early or too late shows up as a wrong busy bit or a missing or spurious interrupt pulse.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;
  localparam int BUSY_BIT  = 31;
  localparam int SPEED_BIT = 27;
  localparam int SIZE_LSB  = 24;
  localparam int SIZE_W    = 3;
  localparam int READY_BIT = 23;
  localparam int RSV_BIT   = 15;
  localparam logic [31:0] WR_KEEP_MASK = ~((32'd1 << READY_BIT) | (32'd1 << RSV_BIT));

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DATA, S_WAIT} xferState_e;

  typedef struct packed {
    logic startXfer;
    logic shiftByte;
    logic setReady;
    logic clrReady;
    logic endXfer;
  } xferStrobe_t;
endpackage

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl
  import cart_xfer_pkg::*;
#(
  parameter int CYC_FAST    = 5,
  parameter int CYC_SLOW    = 8,
  parameter int CMD_BYTES   = 8,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_WORDS = 64,
  parameter int WORDS_W     = 13,
  parameter int BYTE_W      = $clog2(CMD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              startBit,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              portEnable,
  input  logic              dataRdEn,
  input  logic              speedSlow,
  output xferStrobe_t       strb,
  output logic              busStrobe,
  output logic [BYTE_W-1:0] byteIdx
);
  localparam int CYC_W = $clog2(CYC_SLOW);

  xferState_e         state;
  logic [CYC_W-1:0]   cycCnt;
  logic [BYTE_W-1:0]  byteCnt;
  logic [WORDS_W-1:0] wordsLeft;
  logic               byteDone, lastByte, startReq, rdHit, active;
  logic [CYC_W-1:0]   cycLimit;

  function automatic logic [WORDS_W-1:0] wordsFor(logic [SIZE_W-1:0] code);
    if (code == '0) return '0;
    if (code == {SIZE_W{1'b1}}) return WORDS_W'(1);
    return WORDS_W'(BLOCK_WORDS) << code;
  endfunction

  assign cycLimit = speedSlow ? CYC_W'(CYC_SLOW - 1) : CYC_W'(CYC_FAST - 1);
  assign active   = (state == S_CMD) || (state == S_DATA);
  assign byteDone = active && (cycCnt == cycLimit);
  assign lastByte = (state == S_CMD) ? (byteCnt == BYTE_W'(CMD_BYTES - 1))
                                     : (byteCnt == BYTE_W'(WORD_BYTES - 1));
  assign startReq = ctrlWrEn && (state == S_IDLE) && startBit && portEnable;
  assign rdHit    = dataRdEn && (state == S_WAIT);

  always_comb begin
    strb.startXfer = startReq;
    strb.shiftByte = (state == S_DATA) && byteDone;
    strb.setReady  = (state == S_DATA) && byteDone && lastByte;
    strb.clrReady  = rdHit;
    strb.endXfer   = ((state == S_CMD) && byteDone && lastByte && (wordsLeft == '0))
                   || (rdHit && (wordsLeft == '0));
  end

  assign busStrobe = byteDone;
  assign byteIdx   = byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cycCnt    <= '0;
      byteCnt   <= '0;
      wordsLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          state     <= S_CMD;
          cycCnt    <= '0;
          byteCnt   <= '0;
          wordsLeft <= wordsFor(sizeCode);
        end
        S_CMD, S_DATA: begin
          if (byteDone) begin
            cycCnt <= '0;
            if (lastByte) begin
              byteCnt <= '0;
              if (state == S_CMD) begin
                state <= (wordsLeft == '0) ? S_IDLE : S_DATA;
              end else begin
                state     <= S_WAIT;
                wordsLeft <= wordsLeft - WORDS_W'(1);
              end
            end else begin
              byteCnt <= byteCnt + BYTE_W'(1);
            end
          end else begin
            cycCnt <= cycCnt + CYC_W'(1);
          end
        end
        S_WAIT: if (dataRdEn) begin
          state  <= (wordsLeft == '0) ? S_IDLE : S_DATA;
          cycCnt <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cart_xfer_dp.sv
module cart_xfer_dp
  import cart_xfer_pkg::*;
#(
  parameter int CMD_BYTES  = 8,
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = $clog2(CMD_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctrlWrEn,
  input  logic [31:0]            ctrlWrData,
  input  logic                   portIrqEn,
  input  xferStrobe_t            strb,
  input  logic [7:0]             busByteIn,
  input  logic [CMD_BYTES*8-1:0] cmdIn,
  input  logic [BYTE_W-1:0]      byteIdx,
  output logic [31:0]            ctrlReg,
  output logic [WORD_BYTES*8-1:0] dataReg,
  output logic [7:0]             busCmdOut,
  output logic                   irqPulse,
  output logic                   dmaReq
);
  localparam int WORD_W = WORD_BYTES * 8;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic              acceptWr;

  assign acceptWr  = ctrlWrEn && !ctrlReg[BUSY_BIT];
  assign nextWord  = {busByteIn, shiftReg[WORD_W-1:8]};
  assign busCmdOut = cmdIn[8*(CMD_BYTES-1-int'(byteIdx)) +: 8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (acceptWr) begin
      ctrlReg <= (ctrlWrData & WR_KEEP_MASK & ~(32'd1 << BUSY_BIT))
               | (32'(strb.startXfer) << BUSY_BIT);
    end else begin
      if (strb.setReady) ctrlReg[READY_BIT] <= 1'b1;
      if (strb.clrReady) ctrlReg[READY_BIT] <= 1'b0;
      if (strb.endXfer)  ctrlReg[BUSY_BIT]  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
      irqPulse <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      if (strb.shiftByte) shiftReg <= nextWord;
      if (strb.setReady)  dataReg  <= nextWord;
      irqPulse <= strb.endXfer && portIrqEn;
      dmaReq   <= strb.setReady;
    end
  end
endmodule

// File: rtl/cart_rom_xfer.sv
module cart_rom_xfer
  import cart_xfer_pkg::*;
#(
  parameter int CYC_FAST    = 5,
  parameter int CYC_SLOW    = 8,
  parameter int CMD_BYTES   = 8,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_WORDS = 64,
  parameter int WORDS_W     = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWrEn,
  input  logic [31:0]             ctrlWrData,
  output logic [31:0]             ctrlRdData,
  input  logic                    dataRdEn,
  output logic [WORD_BYTES*8-1:0] dataRdData,
  input  logic                    portEnable,
  input  logic                    portIrqEn,
  input  logic [CMD_BYTES*8-1:0]  cmdIn,
  output logic [7:0]              busCmdOut,
  input  logic [7:0]              busByteIn,
  output logic                    busStrobe,
  output logic                    dmaReq,
  output logic                    irqPulse
);
  localparam int BYTE_W = $clog2(CMD_BYTES);

  xferStrobe_t       strb;
  logic [BYTE_W-1:0] byteIdx;
  logic [31:0]       ctrlReg;

  cart_xfer_ctrl #(
    .CYC_FAST(CYC_FAST), .CYC_SLOW(CYC_SLOW), .CMD_BYTES(CMD_BYTES),
    .WORD_BYTES(WORD_BYTES), .BLOCK_WORDS(BLOCK_WORDS), .WORDS_W(WORDS_W),
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn),
    .startBit(ctrlWrData[BUSY_BIT]),
    .sizeCode(ctrlWrData[SIZE_LSB +: SIZE_W]),
    .portEnable(portEnable), .dataRdEn(dataRdEn),
    .speedSlow(ctrlReg[SPEED_BIT]),
    .strb(strb), .busStrobe(busStrobe), .byteIdx(byteIdx)
  );

  cart_xfer_dp #(
    .CMD_BYTES(CMD_BYTES), .WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .portIrqEn(portIrqEn), .strb(strb), .busByteIn(busByteIn), .cmdIn(cmdIn),
    .byteIdx(byteIdx), .ctrlReg(ctrlReg), .dataReg(dataRdData),
    .busCmdOut(busCmdOut), .irqPulse(irqPulse), .dmaReq(dmaReq)
  );

  assign ctrlRdData = ctrlReg;
endmodule

// File: rtl/cart_rom_xfer_chk.sv
module cart_rom_xfer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [31:0] ctrlRdData,
  input logic        dataRdEn,
  input logic [31:0] dataRdData,
  input logic        portIrqEn,
  input logic        dmaReq,
  input logic        irqPulse
);
  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !ctrlRdData[31]);

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(portIrqEn));

  // R4
  dma_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $rose(ctrlRdData[23]));

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[23] |-> ctrlRdData[31]);

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[15]);

  // R10
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData[31] && ctrlWrEn) |=>
      (ctrlRdData[30:24] == $past(ctrlRdData[30:24])) &&
      (ctrlRdData[22:0] == $past(ctrlRdData[22:0])));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdEn && !ctrlRdData[23]) |=> ($stable(dataRdData) || dmaReq));
endmodule

bind cart_rom_xfer cart_rom_xfer_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlRdData(ctrlRdData),
  .dataRdEn(dataRdEn), .dataRdData(dataRdData), .portIrqEn(portIrqEn),
  .dmaReq(dmaReq), .irqPulse(irqPulse)
);

// File: tb/cart_rom_xfer_tb.sv
module cart_rom_xfer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] ctrlRdData;
  logic        dataRdEn = 1'b0;
  logic [31:0] dataRdData;
  logic        portEnable = 1'b0;
  logic        portIrqEn = 1'b0;
  logic [63:0] cmdIn = 64'h0123_4567_89AB_CDEF;
  logic [7:0]  busCmdOut;
  logic [7:0]  busByteIn;
  logic        busStrobe;
  logic        dmaReq;
  logic        irqPulse;

  int total = 0;
  int bad = 0;
  int strobeCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_rom_xfer u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .dataRdEn(dataRdEn), .dataRdData(dataRdData),
    .portEnable(portEnable), .portIrqEn(portIrqEn), .cmdIn(cmdIn),
    .busCmdOut(busCmdOut), .busByteIn(busByteIn), .busStrobe(busStrobe),
    .dmaReq(dmaReq), .irqPulse(irqPulse)
  );

  function automatic logic [7:0] romByte(int n);
    return 8'((n * 29 + 7) ^ (n >> 3));
  endfunction

  always @(posedge clk) if (busStrobe) strobeCnt <= strobeCnt + 1;
  assign busByteIn = romByte(strobeCnt);

  function automatic logic [31:0] expWord(int base, int w);
    int n;
    n = base + 8 + 4 * w;
    return {romByte(n + 3), romByte(n + 2), romByte(n + 1), romByte(n)};
  endfunction

  function automatic int wordsOf(int code);
    if (code == 0) return 0;
    if (code == 7) return 1;
    return 64 << code;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runXfer(int code, bit slow, bit irqEn, bit midWrite);
    int p, nw, base;
    logic [31:0] wr, expCtrl;
    p = slow ? 8 : 5;
    nw = wordsOf(code);
    wr = 32'h8000_0000 | (32'(slow) << 27) | (32'(code) << 24) | 32'h0080_92A5;
    expCtrl = wr & 32'hFF7F_7FFF;
    portEnable = 1'b1;
    portIrqEn = irqEn;
    base = strobeCnt;
    ctrlWrEn = 1'b1;
    ctrlWrData = wr;
    tick();
    ctrlWrEn = 1'b0;
    check(ctrlRdData == expCtrl, "R2 start write", ctrlRdData, expCtrl);
    check(busCmdOut == cmdIn[63:56], "R11 first cmd byte", busCmdOut, cmdIn[63:56]);
    if (nw == 0) begin
      for (int k = 1; k < 8 * p; k++) begin
        tick();
        check(busCmdOut == cmdIn[8*(7-k/p) +: 8], "R11 cmd byte", busCmdOut, cmdIn[8*(7-k/p) +: 8]);
      end
      check(ctrlRdData[31] == 1'b1, "R5 busy before end", ctrlRdData[31], 1);
      tick();
      check(ctrlRdData[31] == 1'b0, "R5 zero length end", ctrlRdData[31], 0);
      check(ctrlRdData[23] == 1'b0, "R5 no ready", ctrlRdData[23], 0);
      check(irqPulse == irqEn, "R9 irq zero length", irqPulse, irqEn);
      tick();
      check(irqPulse == 1'b0, "R9 irq one cycle", irqPulse, 0);
      return;
    end
    for (int k = 1; k < 12 * p; k++) begin
      if (midWrite && k == 3) begin
        ctrlWrEn = 1'b1;
        ctrlWrData = 32'h0000_0000;
      end
      tick();
      ctrlWrEn = 1'b0;
      if (midWrite && k == 3)
        check(ctrlRdData == expCtrl, "R10 write while busy", ctrlRdData, expCtrl);
      if (k < 8 * p)
        check(busCmdOut == cmdIn[8*(7-k/p) +: 8], "R11 cmd byte", busCmdOut, cmdIn[8*(7-k/p) +: 8]);
    end
    check(ctrlRdData[23] == 1'b0, "R4 not ready at 12P-1", ctrlRdData[23], 0);
    tick();
    check(ctrlRdData[23] == 1'b1, "R4 ready at 12P", ctrlRdData[23], 1);
    check(dmaReq == 1'b1, "R4 dma request", dmaReq, 1);
    tick();
    check(dmaReq == 1'b0, "R4 dma one cycle", dmaReq, 0);
    for (int w = 0; w < nw; w++) begin
      check(dataRdData == expWord(base, w), "R11 data word", dataRdData, expWord(base, w));
      dataRdEn = 1'b1;
      tick();
      dataRdEn = 1'b0;
      check(ctrlRdData[23] == 1'b0, "R6 read clears ready", ctrlRdData[23], 0);
      if (w == nw - 1) begin
        check(ctrlRdData[31] == 1'b0, "R9 busy clears on last read", ctrlRdData[31], 0);
        check(irqPulse == irqEn, "R9 irq on end", irqPulse, irqEn);
        tick();
        check(irqPulse == 1'b0, "R9 irq one cycle", irqPulse, 0);
      end else begin
        check(ctrlRdData[31] == 1'b1, "R8 busy while words remain", ctrlRdData[31], 1);
        for (int k = 1; k < 4 * p; k++) begin
          if (k == 2) dataRdEn = 1'b1;
          tick();
          dataRdEn = 1'b0;
          if (k == 2)
            check(dataRdData == expWord(base, w), "R7 idle read keeps word", dataRdData, expWord(base, w));
        end
        check(ctrlRdData[23] == 1'b0, "R6 not ready at 4P-1", ctrlRdData[23], 0);
        tick();
        check(ctrlRdData[23] == 1'b1, "R6 ready at 4P", ctrlRdData[23], 1);
        check(dmaReq == 1'b1, "R6 dma request", dmaReq, 1);
      end
    end
  endtask

  initial begin
    repeat (3) tick();
    check(ctrlRdData == 32'h0, "R1 reset ctrl", ctrlRdData, 0);
    check(dataRdData == 32'h0, "R1 reset data", dataRdData, 0);
    check(irqPulse == 1'b0 && dmaReq == 1'b0, "R1 reset pulses", {irqPulse, dmaReq}, 0);
    rstN = 1'b1;
    tick();

    portEnable = 1'b0;
    ctrlWrEn = 1'b1;
    ctrlWrData = 32'hFFFF_FFFF;
    tick();
    ctrlWrEn = 1'b0;
    check(ctrlRdData == 32'h7F7F_7FFF, "R2 masked store", ctrlRdData, 32'h7F7F_7FFF);
    for (int k = 0; k < 12 * 8 + 4; k++) begin
      check(busStrobe == 1'b0 && ctrlRdData[23] == 1'b0, "R3 no transfer without enable",
            {busStrobe, ctrlRdData[23]}, 0);
      tick();
    end
    check(ctrlRdData[31] == 1'b0, "R3 busy stays clear", ctrlRdData[31], 0);

    foreach (cmdIn[i]) ;
    for (int s = 0; s < 2; s++) begin
      runXfer(0, s[0], 1'b1, 1'b0);
      runXfer(7, s[0], s[0], 1'b1);
      runXfer(1, s[0], ~s[0], 1'b0);
      cmdIn = {cmdIn[55:0], cmdIn[63:56] ^ 8'h5A};
      runXfer(2, s[0], 1'b1, 1'b1);
      runXfer(3, s[0], 1'b0, 1'b0);
    end
    runXfer(0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule